// File: doc/BRIEF.md
# Cascaded Two-Stage FIR Notch Filter

This block removes two narrow interfering tones from a stream of 16-bit signed Q15 samples. Each sample goes through two FIR stages in series. Each stage has its own delay line of `NTAPS` entries and its own set of `NTAPS` coefficients. Each stage also has one multiply-accumulate unit, which steps through its taps one per clock cycle.

A sample is taken on a valid/ready handshake. It is placed at the head of the first delay line, and the first sum is formed. That sum is rescaled by a fixed Q15 shift with saturation, and the result becomes the head of the second delay line. The second sum is then formed, rescaled and saturated to give the output. Only after both sums are complete do both delay lines move by one place. The result is held on an output valid/ready handshake until it is taken, and only then is a new sample accepted.

Coefficients are loaded through a one-cycle write port. That port has effect only while the filter is idle.

Top module: `dual_notch_fir`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. All coefficients and all delay-line entries are zero, so a first sample after reset with no coefficient writes yields output 0.
- R2: A sample is accepted in a cycle where `in_valid` and `in_ready` are both 1. After that, `in_ready` stays 0 until the result has been taken. A result is taken in a cycle where `out_valid` and `out_ready` are both 1. In the cycle after it is taken, `in_ready` is 1 and `out_valid` is 0.
- R3: The accepted sample is written to position 0 of the first delay line before the first sum is formed. The first sum is `sum over i=0..NTAPS-1 of c1[i]*d1[i]`, held in a 40-bit accumulator that is cleared for every sample.
- R4: The value written to position 0 of the second delay line is the first sum arithmetically shifted right by 15, saturated to the range -32768..32767.
- R5: The second sum is `sum over i of c2[i]*d2[i]`, formed with the second stage's own coefficients in its own accumulator, which is also cleared for every sample.
- R6: `out_sample` equals the second sum arithmetically shifted right by 15 and saturated to -32768..32767.
- R7: After both sums are done, every delay-line entry at position i>0 takes the value that position i-1 held. Position 0 keeps its value until the next sample overwrites it.
- R8: When `cw_en` is 1 while `in_ready` is 1, `cw_value` is written to tap `cw_index`. `cw_stage` selects the set: 0 writes the first stage, 1 writes the second. The new value applies from the next accepted sample.
- R9: Any coefficient write presented while `in_ready` is 0 is ignored. This covers both the time while a sample is being processed and the time while its result waits to be taken.
- R10: `out_valid` rises exactly 2*NTAPS+2 clock cycles after the edge at which the sample was accepted.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sample` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Filter is idle and will take a sample |
| in_sample | input | 16 | Input sample, signed Q15 |
| out_valid | output | 1 | Filtered result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_sample | output | 16 | Filtered result, signed Q15 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_stage | input | 1 | Coefficient set select: 0 first stage, 1 second stage |
| cw_index | input | $clog2(NTAPS) | Tap number to write |
| cw_value | input | 16 | Coefficient value, signed Q15 |

## Verification
The bound checker covers the handshake rules on every cycle:
- no second sample is accepted while one is in flight;
- `in_ready` and `out_valid` are never both 1;
- the result is held stable under back-pressure;
- the release happens in the cycle after the result is taken;
- the exact 2*NTAPS+2 cycle latency holds.

The arithmetic can only be shown by the bench's scenarios, which compare each output with a reference model. That arithmetic covers the per-sample accumulator clear, the placement of the new sample, the saturating rescale between the stages, the delay-line shift after both sums, and the output saturation. The same holds for the coefficient port rules: a write while busy is ignored, while a write while idle applies to the next sample. The bench shows these only through the values of later outputs.

// File: rtl/notch_pkg.sv
package notch_pkg;

    localparam int DW   = 16;
    localparam int FRAC = 15;
    localparam int PW   = 2 * DW;
    localparam int ACCW = 40;

    typedef logic signed [DW-1:0]   sample_t;
    typedef logic signed [PW-1:0]   prod_t;
    typedef logic signed [ACCW-1:0] acc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN1,
        ST_XFER,
        ST_RUN2,
        ST_SHIFT,
        ST_DONE
    } fir_state_t;

    localparam acc_t SAT_HI = acc_t'((2 ** (DW - 1)) - 1);
    localparam acc_t SAT_LO = -acc_t'(2 ** (DW - 1));

    // Arithmetic shift by the Q15 fraction, then clamp to the sample range.
    function automatic sample_t q15_sat(input acc_t a);
        acc_t s;
        s = a >>> FRAC;
        if (s > SAT_HI)
            return sample_t'(SAT_HI[DW-1:0]);
        else if (s < SAT_LO)
            return sample_t'(SAT_LO[DW-1:0]);
        else
            return sample_t'(s[DW-1:0]);
    endfunction

    function automatic acc_t widen(input prod_t p);
        return {{(ACCW - PW){p[PW-1]}}, p};
    endfunction

endpackage

// File: rtl/notch_stage.sv
module notch_stage
    import notch_pkg::*;
#(
    parameter int NTAPS = 16,
    localparam int IW = $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          coef_we,
    input  logic [IW-1:0] coef_idx,
    input  sample_t       coef_val,
    input  logic          head_we,
    input  sample_t       head_val,
    input  logic          acc_clr,
    input  logic          mac_en,
    input  logic [IW-1:0] tap_idx,
    input  logic          shift_en,
    output acc_t          acc_o
);

    sample_t coef [NTAPS];
    sample_t dly  [NTAPS];
    acc_t    acc;
    prod_t   prod;

    always_comb begin
        prod = coef[tap_idx] * dly[tap_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) begin
                coef[i] <= '0;
                dly[i]  <= '0;
            end
            acc <= '0;
        end else begin
            if (coef_we)
                coef[coef_idx] <= coef_val;
            if (shift_en) begin
                for (int i = NTAPS - 1; i > 0; i--)
                    dly[i] <= dly[i-1];
            end
            if (head_we)
                dly[0] <= head_val;
            if (acc_clr)
                acc <= '0;
            else if (mac_en)
                acc <= acc + widen(prod);
        end
    end

    assign acc_o = acc;

endmodule

// File: rtl/notch_ctrl.sv
module notch_ctrl
    import notch_pkg::*;
#(
    parameter int NTAPS = 16,
    localparam int IW = $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          accept,
    output logic          head1_we,
    output logic [1:0]    mac_en,
    output logic          shift_en,
    output logic [IW-1:0] tap_idx
);

    localparam logic [IW-1:0] LAST_TAP = IW'(NTAPS - 1);

    fir_state_t    state;
    logic [IW-1:0] idx;

    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
        accept    = in_ready && in_valid;
        head1_we  = (state == ST_XFER);
        mac_en    = {state == ST_RUN2, state == ST_RUN1};
        shift_en  = (state == ST_SHIFT);
        tap_idx   = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_RUN1;
                        idx   <= '0;
                    end
                end
                ST_RUN1: begin
                    if (idx == LAST_TAP) begin
                        state <= ST_XFER;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_XFER: state <= ST_RUN2;
                ST_RUN2: begin
                    if (idx == LAST_TAP) begin
                        state <= ST_SHIFT;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SHIFT: state <= ST_DONE;
                ST_DONE: begin
                    if (out_ready)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dual_notch_fir.sv
module dual_notch_fir
    import notch_pkg::*;
#(
    parameter int NTAPS = 16,
    localparam int IW = $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [15:0]   in_sample,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [15:0]   out_sample,
    input  logic          cw_en,
    input  logic          cw_stage,
    input  logic [IW-1:0] cw_index,
    input  logic [15:0]   cw_value
);

    logic          accept;
    logic          head1_we;
    logic [1:0]    mac_en;
    logic          shift_en;
    logic [IW-1:0] tap_idx;
    logic [1:0]    coef_we;
    logic [1:0]    head_we;
    sample_t       head_val [2];
    acc_t          acc_v    [2];
    sample_t       result_q;

    notch_ctrl #(.NTAPS(NTAPS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .accept   (accept),
        .head1_we (head1_we),
        .mac_en   (mac_en),
        .shift_en (shift_en),
        .tap_idx  (tap_idx)
    );

    assign coef_we = {cw_en && in_ready && cw_stage, cw_en && in_ready && !cw_stage};
    assign head_we = {head1_we, accept};

    for (genvar g = 0; g < 2; g++) begin : g_stage
        if (g == 0) begin : g_head_in
            assign head_val[g] = sample_t'(in_sample);
        end else begin : g_head_rescale
            assign head_val[g] = q15_sat(acc_v[0]);
        end

        notch_stage #(.NTAPS(NTAPS)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .coef_we (coef_we[g]),
            .coef_idx(cw_index),
            .coef_val(sample_t'(cw_value)),
            .head_we (head_we[g]),
            .head_val(head_val[g]),
            .acc_clr (accept),
            .mac_en  (mac_en[g]),
            .tap_idx (tap_idx),
            .shift_en(shift_en),
            .acc_o   (acc_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            result_q <= '0;
        else if (shift_en)
            result_q <= q15_sat(acc_v[1]);
    end

    assign out_sample = result_q;

endmodule

// File: rtl/notch_chk.sv
module notch_chk #(
    parameter int NTAPS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_sample
);

    localparam int LAT = 2 * NTAPS + 2;

    logic [31:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            lat_cnt <= '0;
        else if (in_valid && in_ready)
            lat_cnt <= '0;
        else if (!in_ready && !out_valid)
            lat_cnt <= lat_cnt + 1;
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_NO_READY_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R2
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid)); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample))); // R11
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (lat_cnt == LAT)); // R10

endmodule

bind dual_notch_fir notch_chk #(.NTAPS(NTAPS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sample(out_sample)
);

// File: tb/dual_notch_fir_bench.sv
module dual_notch_fir_bench;

    localparam int NT = 16;
    localparam int IW = $clog2(NT);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_sample = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [15:0]   out_sample;
    logic          cw_en = 1'b0;
    logic          cw_stage = 1'b0;
    logic [IW-1:0] cw_index = '0;
    logic [15:0]   cw_value = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    longint h1 [NT];
    longint h2 [NT];
    longint d1 [NT];
    longint d2 [NT];

    always #2 clk = ~clk;

    dual_notch_fir #(.NTAPS(NT)) u_dual_notch_fir (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .cw_en(cw_en), .cw_stage(cw_stage), .cw_index(cw_index), .cw_value(cw_value)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint msat(input longint a);
        longint s;
        s = a >>> 15;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    // Reference step: head write, two sums, rescale, then shift of both lines.
    function automatic longint model_step(input longint x);
        longint a1, a2, y;
        a1 = 0;
        a2 = 0;
        d1[0] = x;
        for (int i = 0; i < NT; i++) a1 += h1[i] * d1[i];
        d2[0] = msat(a1);
        for (int i = 0; i < NT; i++) a2 += h2[i] * d2[i];
        y = msat(a2);
        for (int i = NT - 1; i > 0; i--) begin
            d1[i] = d1[i-1];
            d2[i] = d2[i-1];
        end
        return y;
    endfunction

    task automatic wr_coef(input bit stage, input int idx, input longint val);
        @(negedge clk);
        cw_en = 1'b1;
        cw_stage = stage;
        cw_index = IW'(idx);
        cw_value = 16'(val);
        @(negedge clk);
        cw_en = 1'b0;
        if (stage) h2[idx] = val; else h1[idx] = val;
    endtask

    task automatic run_sample(input longint x, input int stall, input bit busy_wr, input string tag);
        longint exp_y;
        longint held;
        int cnt;
        exp_y = model_step(x);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(x);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 0;
        while (!out_valid && cnt < 1000) begin
            if (busy_wr && cnt == 2) begin
                cw_en = 1'b1; cw_stage = 1'b0; cw_index = '0; cw_value = 16'h4000;
            end else if (busy_wr && cnt == 3) begin
                cw_en = 1'b1; cw_stage = 1'b1; cw_index = IW'(1); cw_value = 16'h4000;
            end else begin
                cw_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        cw_en = 1'b0;
        chk(cnt == 2 * NT + 2, "R10 latency", cnt, 2 * NT + 2);
        held = longint'($signed(out_sample));
        for (int s = 0; s < stall; s++) begin
            if (busy_wr && s == 0) begin
                cw_en = 1'b1; cw_stage = 1'b0; cw_index = IW'(2); cw_value = 16'h4000;
            end else begin
                cw_en = 1'b0;
            end
            @(negedge clk);
            chk(out_valid && longint'($signed(out_sample)) == held,
                "R11 hold under back-pressure", longint'($signed(out_sample)), held);
        end
        cw_en = 1'b0;
        chk(longint'($signed(out_sample)) == exp_y, tag, longint'($signed(out_sample)), exp_y);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready && !out_valid, "R2 release after take", {in_ready, out_valid}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));
        for (int i = 0; i < NT; i++) begin
            h1[i] = 0; h2[i] = 0; d1[i] = 0; d2[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

        // R1: cleared coefficients give a zero result.
        run_sample(12345, 0, 0, "R1 zero coefficients");

        // R8: load both coefficient sets while idle.
        for (int i = 0; i < NT; i++) begin
            wr_coef(0, i, longint'($urandom_range(0, 20000)) - 10000);
            wr_coef(1, i, longint'($urandom_range(0, 20000)) - 10000);
        end

        // R3 R4 R5 R6 R7: random stream through both stages.
        for (int n = 0; n < 30; n++)
            run_sample(longint'($urandom_range(0, 50000)) - 25000, 0, 0, "R6 random stream");

        // R9: writes while busy and while waiting are ignored.
        run_sample(longint'($urandom_range(0, 20000)) - 10000, 3, 1, "R9 busy write ignored");
        for (int n = 0; n < 4; n++)
            run_sample(longint'($urandom_range(0, 20000)) - 10000, 0, 0, "R9 later outputs unaffected");

        // R7: impulse through unit-weight taps exposes the shift order.
        for (int i = 0; i < NT; i++) begin
            wr_coef(0, i, (i == 3) ? 32767 : 0);
            wr_coef(1, i, (i == 0) ? 32767 : 0);
        end
        run_sample(20000, 0, 0, "R3 impulse head");
        for (int n = 0; n < 5; n++)
            run_sample(0, 0, 0, "R7 delayed impulse");

        // R4 R6: positive and negative saturation.
        for (int i = 0; i < NT; i++) begin
            wr_coef(0, i, 32767);
            wr_coef(1, i, 32767);
        end
        for (int n = 0; n < 4; n++)
            run_sample(32767, 2, 0, "R4 positive saturation");
        for (int n = 0; n < 20; n++)
            run_sample(-32768, 0, 0, "R6 negative saturation");
        wr_coef(1, 5, -32768);
        run_sample(-32768, 1, 0, "R5 stage two own set");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule